// File: doc/BRIEF.md
# Serial Write-All Memory Slave

This block is a small serial memory slave for a three-wire select/clock/data link. All link inputs are sampled on a fast system clock. A command opens with a start bit, carries a two-bit opcode and an address field, and may carry a data word. The block keeps a write-enable latch that an enable command sets and a disable command clears. Its main operation is write-all. Once the enable latch is set, write-all takes one data word from the link. A self-timed cycle then first sets every word of the register array to all ones and then fills every word with that data word. The cycle needs no further serial clocks.

A parameter picks the trigger for the self-timed cycle. In one variant the cycle starts when select falls after the last data bit. In the other it starts on the serial clock edge that samples the last data bit. A second parameter turns on a program-enable input, which must be high at that last data edge. Status appears on the output when select is raised again after a long enough low time: low while the cycle runs, high once it has finished. The ready indication stays pending until a start bit is sent and select is dropped. A single-word read command exists so that the array contents can be checked over the link.

Top module: `mw_wral_mem`

## Requirements
- R1: Bits are taken from `di` MSB first on each rising edge of `sclk` while `cs` is high. Zeros before the first 1 are skipped. A command is a 1 start bit, then a 2-bit opcode, then ADDR_W address bits.
- R2: Opcode 00 with address top bits 11 sets the write-enable latch. Opcode 00 with top bits 00 clears it. A write-all sent while the latch is clear changes nothing.
- R3: Opcode 00 with top bits 01 (the other address bits are don't-care) is write-all. It is followed by DATA_W data bits, MSB first. When accepted, every array word ends up equal to that data word.
- R4: When PE_CHECK is 1, a write-all is rejected unless `pe` is high on the rising `sclk` edge of the last data bit.
- R5: With TRIG_CS_FALL=1 the cycle starts when `cs` falls after the last data bit. With TRIG_CS_FALL=0 it starts on the last data bit's rising `sclk` edge. In both variants it finishes with no further `sclk` edges.
- R6: The cycle lasts CYCLE_LEN system clocks. It sets every word to all ones when it starts and writes the data word when it ends.
- R7: Status is shown when `cs` rises after at least CSL_MIN clocks low while a cycle is running or a ready indication is pending. `do_oe`=1, with `do_val`=0 while busy and 1 when ready. A shorter low leaves `do_oe`=0.
- R8: After completion, a start bit followed by `cs` going low clears the pending ready indication. The next `cs` rise leaves `do_oe`=0.
- R9: Start bits arriving while a cycle runs are ignored, so no command takes effect.
- R10: Opcode 10 reads the addressed word. After the last address bit, `do_oe`=1 and `do_val` gives the word MSB first, advancing on each later rising `sclk`. `do_oe` is 0 whenever `cs` is low.
- R11: Reset leaves `do_oe`=0, the array all zeros, and the write-enable latch clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Serial select, active high |
| sclk | input | 1 | Serial bit clock |
| di | input | 1 | Serial data in |
| pe | input | 1 | Program-enable qualifier |
| do_val | output | 1 | Serial data/status value |
| do_oe | output | 1 | Output enable for do_val (0 = high impedance) |

## Verification
Two instances, one per trigger variant, share the same stimulus. One of them holds select high well past the cycle length after the last bit. A design that took the trigger from the wrong edge would then report ready and busy the wrong way round. The bench also probes status after select-low times just below and above the minimum, so a design that ignored the low-time rule shows status too early. Write-all is tried with the latch clear, with program-enable low, and with a write-disable sent in the middle of a busy cycle. A design that did not gate on each of these, or accepted commands while busy, would change the array, and the reads back expose that. Random data words with random don't-care address bits check that every location receives the same word.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        F_IDLE,
        F_OPC,
        F_ADDR,
        F_DATA,
        F_READ,
        F_DONE
    } frame_e;

    localparam logic [1:0] OP_MISC  = 2'b00;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] SUB_WEN  = 2'b11;
    localparam logic [1:0] SUB_WDS  = 2'b00;
    localparam logic [1:0] SUB_WALL = 2'b01;

    function automatic logic write_allowed(input logic wen, input logic pe, input logic pe_check);
        return wen && (pe || !pe_check);
    endfunction

endpackage

// File: rtl/mw_frame.sv
module mw_frame
    import mw_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 8,
    parameter bit TRIG_CS_FALL = 1'b1,
    parameter bit PE_CHECK     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_fall,
    input  logic              bit_rise,
    input  logic              di,
    input  logic              pe,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] addr_nxt,
    output logic              start_seen,
    output logic              go,
    output logic [DATA_W-1:0] wr_data,
    output logic              wen,
    output logic              rd_on,
    output logic              rd_bit
);
    localparam int MAXB = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int CW   = $clog2(MAXB + 1);
    localparam logic [CW-1:0] A_LAST = CW'(ADDR_W - 1);
    localparam logic [CW-1:0] D_LAST = CW'(DATA_W - 1);
    localparam logic [CW-1:0] O_LAST = CW'(1);

    frame_e            st;
    logic [CW-1:0]     cnt;
    logic [1:0]        op;
    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-1:0] data_sh;
    logic [DATA_W-1:0] data_nxt;
    logic [DATA_W-1:0] rd_sh;
    logic [1:0]        sub;
    logic              armed;
    logic              ok;

    assign addr_nxt = {addr_sh[ADDR_W-2:0], di};
    assign data_nxt = {data_sh[DATA_W-2:0], di};
    assign sub      = addr_nxt[ADDR_W-1 -: 2];
    assign ok       = write_allowed(wen, pe, PE_CHECK);
    assign rd_bit   = rd_sh[DATA_W-1];

    always_ff @(posedge clk) begin
        start_seen <= 1'b0;
        go         <= 1'b0;
        if (rst) begin
            st      <= F_IDLE;
            cnt     <= '0;
            op      <= '0;
            addr_sh <= '0;
            data_sh <= '0;
            wr_data <= '0;
            wen     <= 1'b0;
            armed   <= 1'b0;
            rd_on   <= 1'b0;
            rd_sh   <= '0;
        end else if (cs_fall) begin
            st    <= F_IDLE;
            rd_on <= 1'b0;
            if (armed) begin
                go    <= 1'b1;
                armed <= 1'b0;
            end
        end else if (bit_rise) begin
            cnt <= cnt + 1'b1;
            case (st)
                F_IDLE: begin
                    if (di && !busy) begin
                        st         <= F_OPC;
                        cnt        <= '0;
                        start_seen <= 1'b1;
                    end
                end
                F_OPC: begin
                    op <= {op[0], di};
                    if (cnt == O_LAST) begin
                        st  <= F_ADDR;
                        cnt <= '0;
                    end
                end
                F_ADDR: begin
                    addr_sh <= addr_nxt;
                    if (cnt == A_LAST) begin
                        cnt <= '0;
                        st  <= F_DONE;
                        if (op == OP_READ) begin
                            st    <= F_READ;
                            rd_on <= 1'b1;
                            rd_sh <= rd_word;
                        end else if (op == OP_MISC) begin
                            case (sub)
                                SUB_WEN:  wen <= 1'b1;
                                SUB_WDS:  wen <= 1'b0;
                                SUB_WALL: st  <= F_DATA;
                                default:  ;
                            endcase
                        end
                    end
                end
                F_DATA: begin
                    data_sh <= data_nxt;
                    if (cnt == D_LAST) begin
                        st <= F_DONE;
                        if (ok) wr_data <= data_nxt;
                        if (TRIG_CS_FALL) armed <= ok;
                        else              go    <= ok;
                    end
                end
                F_READ: rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
    parameter int CYCLE_LEN = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic erase,
    output logic done
);
    localparam int TW = $clog2(CYCLE_LEN + 1);
    localparam logic [TW-1:0] T_LAST = TW'(CYCLE_LEN - 1);

    logic [TW-1:0] tcnt;

    assign erase = go && !busy;
    assign done  = busy && (tcnt == T_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            tcnt <= '0;
        end else if (erase) begin
            busy <= 1'b1;
            tcnt <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            tcnt <= tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/mw_store.sv
module mw_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           erase,
    input  logic                           prog,
    input  logic [DATA_W-1:0]              data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_word,
    output logic [(1<<ADDR_W)*DATA_W-1:0]  mem_flat
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)        words[g] <= '0;
            else if (erase) words[g] <= '1;
            else if (prog)  words[g] <= data;
        end
        assign mem_flat[g*DATA_W +: DATA_W] = words[g];
    end

    assign rd_word = words[rd_addr];
endmodule

// File: rtl/mw_wral_mem.sv
module mw_wral_mem #(
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 8,
    parameter int CYCLE_LEN    = 40,
    parameter int CSL_MIN      = 8,
    parameter bit TRIG_CS_FALL = 1'b1,
    parameter bit PE_CHECK     = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sclk,
    input  logic di,
    input  logic pe,
    output logic do_val,
    output logic do_oe
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int LW    = $clog2(CSL_MIN + 1);
    localparam logic [LW-1:0] L_MAX = LW'(CSL_MIN);

    logic                    sclk_q, cs_q;
    logic                    bit_rise, cs_fall, cs_rise;
    logic [LW-1:0]           low_cnt;
    logic                    rdy, saw_start, stat_on;
    logic                    busy, erase, done, go, wen, rd_on, rd_bit, start_seen;
    logic [ADDR_W-1:0]       addr_nxt;
    logic [DATA_W-1:0]       wr_data, rd_word;
    logic [WORDS*DATA_W-1:0] mem_flat;

    assign bit_rise = sclk && !sclk_q && cs;
    assign cs_fall  = !cs && cs_q;
    assign cs_rise  = cs && !cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            cs_q      <= 1'b0;
            low_cnt   <= '0;
            rdy       <= 1'b0;
            saw_start <= 1'b0;
            stat_on   <= 1'b0;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs;
            if (cs_fall)                       low_cnt <= LW'(1);
            else if (!cs && low_cnt != L_MAX)  low_cnt <= low_cnt + 1'b1;

            if (done)                          rdy <= 1'b1;
            else if (go)                       rdy <= 1'b0;
            else if (cs_fall && saw_start)     rdy <= 1'b0;

            if (cs_fall)                       saw_start <= 1'b0;
            else if (start_seen && rdy)        saw_start <= 1'b1;

            if (cs_fall || start_seen)         stat_on <= 1'b0;
            else if (cs_rise && low_cnt >= L_MAX && (busy || rdy))
                                               stat_on <= 1'b1;
        end
    end

    assign do_oe  = stat_on || rd_on;
    assign do_val = stat_on ? !busy : (rd_on && rd_bit);

    mw_frame #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .TRIG_CS_FALL(TRIG_CS_FALL), .PE_CHECK(PE_CHECK)
    ) u_frame (
        .clk(clk), .rst(rst), .cs_fall(cs_fall), .bit_rise(bit_rise),
        .di(di), .pe(pe), .busy(busy), .rd_word(rd_word),
        .addr_nxt(addr_nxt), .start_seen(start_seen), .go(go),
        .wr_data(wr_data), .wen(wen), .rd_on(rd_on), .rd_bit(rd_bit)
    );

    mw_timer #(.CYCLE_LEN(CYCLE_LEN)) u_timer (
        .clk(clk), .rst(rst), .go(go), .busy(busy), .erase(erase), .done(done)
    );

    mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .erase(erase), .prog(done), .data(wr_data),
        .rd_addr(addr_nxt), .rd_word(rd_word), .mem_flat(mem_flat)
    );
endmodule

// File: rtl/mw_chk.sv
module mw_chk #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CYCLE_LEN = 40
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             cs,
    input logic                             do_oe,
    input logic                             busy,
    input logic                             wen,
    input logic                             start_seen,
    input logic [DATA_W-1:0]                wr_data,
    input logic [(1<<ADDR_W)*DATA_W-1:0]    mem_flat
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int BW    = $clog2(CYCLE_LEN + 2);

    logic [BW-1:0] blen;
    always_ff @(posedge clk) begin
        if (rst)       blen <= '0;
        else if (busy) blen <= blen + 1'b1;
        else           blen <= '0;
    end

    assert_oe_needs_cs_R10: assert property (@(posedge clk) disable iff (rst)
        do_oe |-> $past(cs));

    assert_start_needs_wen_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wen));

    assert_erase_ones_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mem_flat == '1));

    assert_fill_word_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (mem_flat == {WORDS{wr_data}}));

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (blen == BW'(CYCLE_LEN)));

    assert_no_cmd_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> !start_seen);
endmodule

bind mw_wral_mem mw_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYCLE_LEN(CYCLE_LEN)
) u_chk (
    .clk(clk), .rst(rst), .cs(cs), .do_oe(do_oe), .busy(busy), .wen(wen),
    .start_seen(start_seen), .wr_data(wr_data), .mem_flat(mem_flat)
);

// File: tb/sim_mw_wral_mem.sv
`timescale 1ns/1ps
module sim_mw_wral_mem;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int CL = 40;
    localparam int CM = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, sclk = 1'b0, di = 1'b0, pe = 1'b0;
    logic do_val0, do_oe0, do_val1, do_oe1;
    int   n_chk = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;

    mw_wral_mem #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_LEN(CL), .CSL_MIN(CM),
                  .TRIG_CS_FALL(1'b1), .PE_CHECK(1'b1)) u0 (
        .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .di(di), .pe(pe),
        .do_val(do_val0), .do_oe(do_oe0));

    mw_wral_mem #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_LEN(CL), .CSL_MIN(CM),
                  .TRIG_CS_FALL(1'b0), .PE_CHECK(1'b1)) u1 (
        .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .di(di), .pe(pe),
        .do_val(do_val1), .do_oe(do_oe1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] status_exp(input logic shown, input logic ready);
        return shown ? {1'b1, ready} : 2'b00;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        di = b;
        wait_n(2); sclk = 1'b1;
        wait_n(2); sclk = 1'b0;
        wait_n(2);
    endtask

    task automatic open_cs();
        cs = 1'b1; wait_n(2);
    endtask

    task automatic close_cs(input int n);
        cs = 1'b0; di = 1'b0; wait_n(n);
    endtask

    task automatic head(input logic [1:0] op, input logic [AW-1:0] a);
        bit_out(1'b1);
        for (int i = 1; i >= 0; i--) bit_out(op[i]);
        for (int i = AW - 1; i >= 0; i--) bit_out(a[i]);
    endtask

    task automatic misc_cmd(input logic [1:0] sub);
        open_cs();
        head(2'b00, {sub, 2'($urandom)});
        close_cs(12);
    endtask

    task automatic wral(input logic [DW-1:0] d, input logic pe_v, input int hold);
        open_cs();
        pe = pe_v;
        head(2'b00, {2'b01, 2'($urandom)});
        for (int i = DW - 1; i >= 0; i--) bit_out(d[i]);
        wait_n(hold);
        pe = 1'b0;
        close_cs(12);
    endtask

    task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] g0, g1;
        logic oe_ok;
        open_cs();
        head(2'b10, a);
        oe_ok = do_oe0 && do_oe1;
        for (int i = DW - 1; i >= 0; i--) begin
            g0[i] = do_val0;
            g1[i] = do_val1;
            if (i > 0) bit_out(1'b0);
        end
        close_cs(12);
        chk({req, " read oe"}, {31'd0, oe_ok}, 32'd1);
        chk({req, " read u0"}, {24'd0, g0}, {24'd0, exp});
        chk({req, " read u1"}, {24'd0, g1}, {24'd0, exp});
    endtask

    task automatic peek(input string req, input logic [1:0] e0, input logic [1:0] e1);
        cs = 1'b1; wait_n(2);
        chk({req, " u0 status"}, {30'd0, do_oe0, do_oe0 & do_val0}, {30'd0, e0});
        chk({req, " u1 status"}, {30'd0, do_oe1, do_oe1 & do_val1}, {30'd0, e1});
        close_cs(12);
    endtask

    task automatic clear_rdy();
        open_cs(); bit_out(1'b1); close_cs(12);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        wait_n(6);
        rst = 1'b0;
        wait_n(2);

        // R11: reset state
        chk("R11 oe after reset", {30'd0, do_oe0, do_oe1}, 32'd0);
        read_chk("R11 R10 R1 zero array", 4'd5, 8'h00);

        // R2: write-all with the latch clear has no effect
        wral(8'hA5, 1'b1, 0);
        peek("R2 no cycle without enable", status_exp(0, 0), status_exp(0, 0));
        read_chk("R2 array untouched", 4'd3, 8'h00);

        // R4: program-enable low rejects
        misc_cmd(2'b11);
        wral(8'h3C, 1'b0, 0);
        peek("R4 pe low no cycle", status_exp(0, 0), status_exp(0, 0));
        read_chk("R4 array untouched", 4'd7, 8'h00);

        // R3 R5 R7 R8: accepted write-all
        wral(8'h96, 1'b1, 0);
        peek("R7 busy shown", status_exp(1, 0), status_exp(1, 0));
        cs = 1'b1; wait_n(2); close_cs(3);
        cs = 1'b1; wait_n(2);
        chk("R7 short low hides status", {30'd0, do_oe0, do_oe1}, 32'd0);
        close_cs(60);
        peek("R7 R5 ready shown", status_exp(1, 1), status_exp(1, 1));
        clear_rdy();
        peek("R8 ready cleared", status_exp(0, 0), status_exp(0, 0));
        for (int a = 0; a < (1 << AW); a++) read_chk("R3 every word", 4'(a), 8'h96);

        // R5: trigger variants differ with cs held high after the last bit
        wral(8'h5A, 1'b1, CL + 10);
        peek("R5 trigger edge", status_exp(1, 0), status_exp(1, 1));
        wait_n(60);
        clear_rdy();
        read_chk("R5 both filled", 4'd9, 8'h5A);

        // R9: a disable command sent while busy is ignored
        wral(8'h11, 1'b1, 0);
        open_cs(); head(2'b00, 4'b0000); close_cs(60);
        clear_rdy();
        wral(8'h22, 1'b1, 0);
        wait_n(60);
        clear_rdy();
        read_chk("R9 enable kept", 4'd14, 8'h22);

        // R2: disable then write-all is ignored
        misc_cmd(2'b00);
        wral(8'h77, 1'b1, 0);
        wait_n(60);
        read_chk("R2 disabled write ignored", 4'd1, 8'h22);

        // R3 R6: random data words
        for (int k = 0; k < 4; k++) begin
            logic [DW-1:0] d;
            d = DW'($urandom);
            misc_cmd(2'b11);
            wral(d, 1'b1, 0);
            wait_n(CL + 20);
            clear_rdy();
            read_chk("R3 R6 random fill", 4'($urandom), d);
            read_chk("R3 R6 random fill", 4'($urandom), d);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule